// File: doc/BRIEF.md
# Watchdog and Wakeup Timer

This block pairs two free-running up counters for an always-on region. The first is a wakeup timer: a programmable prescaler divides the clock, the counter advances on each divided tick, and once the count meets a threshold a wakeup interrupt and a wakeup request are latched. With a 12-bit prescaler in front of a 32-bit count, timeouts of many hours are within reach at ordinary clock rates.

The second counter is a watchdog that advances every clock while enabled. It escalates in two steps. When the count meets a lower "warn" threshold, an interrupt and a non-maskable interrupt are raised. If software still has not serviced it, meeting the higher "expire" threshold raises a reset request. Software keeps the watchdog quiet by rewriting its count, usually to zero. A sticky lock bit freezes the watchdog enable and both thresholds until the next reset.

Software reaches the block through a single-cycle write port and a combinational read port over eight word registers. Reset generation and clock crossing are left to the surrounding logic.

Top module: `wdt_wake_top`

## Requirements
- R1: After reset every output is low, both counts read 0, every threshold reads all ones, and both configuration registers read 0.
- R2: Registers sit at word addresses 0 wake config (bit 0 enable, prescale at bits [PRE_W+3:4]), 1 wake count, 2 wake threshold, 3 watchdog config (bit 0 enable, bit 1 lock), 4 watchdog count, 5 warn threshold, 6 expire threshold, 7 status (bit 0 wake, bit 1 warn, bit 2 expire). Written fields read back unchanged, and unused config bits read 0.
- R3: While the wakeup timer is enabled with prescale value P, its count increases by one every P+1 clocks, and the first increment lands P+1 clocks after the enabling write.
- R4: One clock after an enabled wakeup count is greater than or equal to its threshold, the wakeup interrupt and the wakeup request both go high and stay high until status bit 0 is written with 1.
- R5: The watchdog count increases by one each clock while its enable bit is set and holds its value while the bit is clear.
- R6: One clock after an enabled watchdog count is greater than or equal to the warn threshold, the warn interrupt and the warn non-maskable interrupt both go high and stay high.
- R7: One clock after an enabled watchdog count is greater than or equal to the expire threshold, the reset request goes high and stays high.
- R8: A write to the watchdog count loads the written value and clears the warn and expire outputs in the same clock.
- R9: Writing 1 to watchdog config bit 1 sets a lock that only reset clears. While locked, writes to the watchdog enable and to both thresholds are ignored, and writes to the watchdog count still take effect.
- R10: Both counts stop at all ones instead of wrapping to zero.
- R11: Writing 1 to a status bit clears that latched output. When the clear and the set condition occur in the same clock, the clear wins, and the output returns one clock later if the condition still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write word address |
| wr_data_i | input | CNT_W | Register write data |
| rd_addr_i | input | 4 | Register read word address |
| rd_data_o | output | CNT_W | Register read data, combinational |
| wake_irq_o | output | 1 | Wakeup timer expired interrupt, level |
| wake_req_o | output | 1 | Wakeup request, level |
| warn_irq_o | output | 1 | Watchdog warn interrupt, level |
| warn_nmi_o | output | 1 | Watchdog warn non-maskable interrupt, level |
| rst_req_o | output | 1 | Watchdog expire reset request, level |

## Verification
The bench builds the block with its defaults: a 32-bit count, a 12-bit prescaler and saturating counters. Small thresholds of 2, 10 and 20 put the warn and expire edges within tens of clocks. A prescale of 3 makes the one-in-four tick cadence visible cycle by cycle. Preloading a count of all ones minus one brings the saturation corner within two clocks, and no 32-bit run is needed to reach it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int unsigned RegAddrW = 4;

   typedef enum logic [RegAddrW-1:0] {
      RegWakeCfg  = 4'd0,
      RegWakeCnt  = 4'd1,
      RegWakeThr  = 4'd2,
      RegDogCfg   = 4'd3,
      RegDogCnt   = 4'd4,
      RegWarnThr  = 4'd5,
      RegExpThr   = 4'd6,
      RegStatus   = 4'd7
   } reg_addr_e;

   localparam int unsigned WakeEnBit   = 0;
   localparam int unsigned PrescLsb    = 4;
   localparam int unsigned DogEnBit    = 0;
   localparam int unsigned DogLockBit  = 1;
   localparam int unsigned StWakeBit   = 0;
   localparam int unsigned StWarnBit   = 1;
   localparam int unsigned StExpBit    = 2;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned PRE_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [PRE_W-1:0] limit_i,
   output logic             tick_o
);

   if (PRE_W < 1) begin : g_bad_pre_w
      $error("wdt_prescaler: PRE_W must be at least 1");
   end

   logic [PRE_W-1:0] div_q;

   assign tick_o = en_i && (div_q >= limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= '0;
      end else if (!en_i || tick_o) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   // R3
   tick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> (div_q == '0));

   // R3
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (div_q == '0) && !tick_o || en_i);

endmodule

// File: rtl/wdt_upcounter.sv
module wdt_upcounter #(
   parameter int unsigned W        = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         inc_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] CntMax = {W{1'b1}};

   if (W < 2) begin : g_bad_w
      $error("wdt_upcounter: W must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] step;

   if (SATURATE) begin : g_sat
      assign step = (cnt_q == CntMax) ? cnt_q : cnt_q + 1'b1;

      // R10
      sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (cnt_q == CntMax) && inc_i && !load_i |=> (cnt_q == CntMax));
   end else begin : g_wrap
      assign step = cnt_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (inc_i) begin
         cnt_q <= step;
      end
   end

   assign cnt_o = cnt_q;

   // R5
   idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !inc_i && !load_i |=> $stable(cnt_q));

   // R8
   load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;

   // R11
   clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !flag_q);

   // R6
   set_raises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i && !clr_i |=> flag_q);

   // R4
   sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q && !clr_i |=> flag_q);

endmodule

// File: rtl/wdt_wake_top.sv
module wdt_wake_top
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned PRE_W    = 12,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic [RegAddrW-1:0] wr_addr_i,
   input  logic [CNT_W-1:0]    wr_data_i,
   input  logic [RegAddrW-1:0] rd_addr_i,
   output logic [CNT_W-1:0]    rd_data_o,
   output logic                wake_irq_o,
   output logic                wake_req_o,
   output logic                warn_irq_o,
   output logic                warn_nmi_o,
   output logic                rst_req_o
);

   localparam int unsigned PrescMsb = PrescLsb + PRE_W - 1;
   localparam int unsigned NumFlags = 3;

   if (PrescMsb >= CNT_W) begin : g_bad_field
      $error("wdt_wake_top: prescale field does not fit in CNT_W");
   end
   if (CNT_W > 64) begin : g_bad_cnt_w
      $error("wdt_wake_top: CNT_W above 64 is not supported");
   end

   // Configuration state
   logic             wake_en_q;
   logic [PRE_W-1:0] presc_q;
   logic [CNT_W-1:0] wake_thr_q;
   logic             dog_en_q;
   logic             lock_q;
   logic [CNT_W-1:0] warn_thr_q;
   logic [CNT_W-1:0] exp_thr_q;

   // Write decode
   logic wr_wake_cfg, wr_wake_cnt, wr_wake_thr;
   logic wr_dog_cfg, wr_dog_cnt, wr_warn_thr, wr_exp_thr, wr_status;

   always_comb begin
      wr_wake_cfg = 1'b0;
      wr_wake_cnt = 1'b0;
      wr_wake_thr = 1'b0;
      wr_dog_cfg  = 1'b0;
      wr_dog_cnt  = 1'b0;
      wr_warn_thr = 1'b0;
      wr_exp_thr  = 1'b0;
      wr_status   = 1'b0;
      if (wr_en_i) begin
         case (reg_addr_e'(wr_addr_i))
            RegWakeCfg: wr_wake_cfg = 1'b1;
            RegWakeCnt: wr_wake_cnt = 1'b1;
            RegWakeThr: wr_wake_thr = 1'b1;
            RegDogCfg:  wr_dog_cfg  = 1'b1;
            RegDogCnt:  wr_dog_cnt  = 1'b1;
            RegWarnThr: wr_warn_thr = 1'b1;
            RegExpThr:  wr_exp_thr  = 1'b1;
            RegStatus:  wr_status   = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wake_en_q  <= 1'b0;
         presc_q    <= '0;
         wake_thr_q <= '1;
         dog_en_q   <= 1'b0;
         lock_q     <= 1'b0;
         warn_thr_q <= '1;
         exp_thr_q  <= '1;
      end else begin
         if (wr_wake_cfg) begin
            wake_en_q <= wr_data_i[WakeEnBit];
            presc_q   <= wr_data_i[PrescMsb:PrescLsb];
         end
         if (wr_wake_thr) begin
            wake_thr_q <= wr_data_i;
         end
         if (wr_dog_cfg) begin
            if (!lock_q) begin
               dog_en_q <= wr_data_i[DogEnBit];
            end
            if (wr_data_i[DogLockBit]) begin
               lock_q <= 1'b1;
            end
         end
         if (wr_warn_thr && !lock_q) begin
            warn_thr_q <= wr_data_i;
         end
         if (wr_exp_thr && !lock_q) begin
            exp_thr_q <= wr_data_i;
         end
      end
   end

   // Wakeup path
   logic             wake_tick;
   logic [CNT_W-1:0] wake_cnt;

   wdt_prescaler #(
      .PRE_W (PRE_W)
   ) u_presc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (wake_en_q),
      .limit_i (presc_q),
      .tick_o  (wake_tick)
   );

   wdt_upcounter #(
      .W        (CNT_W),
      .SATURATE (SATURATE)
   ) u_wake_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (wake_tick),
      .load_i     (wr_wake_cnt),
      .load_val_i (wr_data_i),
      .cnt_o      (wake_cnt)
   );

   // Watchdog path
   logic [CNT_W-1:0] dog_cnt;

   wdt_upcounter #(
      .W        (CNT_W),
      .SATURATE (SATURATE)
   ) u_dog_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (dog_en_q),
      .load_i     (wr_dog_cnt),
      .load_val_i (wr_data_i),
      .cnt_o      (dog_cnt)
   );

   // Latched events: index 0 wake, 1 warn, 2 expire
   logic [NumFlags-1:0] ev_set;
   logic [NumFlags-1:0] ev_clr;
   logic [NumFlags-1:0] ev_flag;

   assign ev_set[StWakeBit] = wake_en_q && (wake_cnt >= wake_thr_q);
   assign ev_set[StWarnBit] = dog_en_q  && (dog_cnt  >= warn_thr_q);
   assign ev_set[StExpBit]  = dog_en_q  && (dog_cnt  >= exp_thr_q);

   assign ev_clr[StWakeBit] = wr_status && wr_data_i[StWakeBit];
   assign ev_clr[StWarnBit] = wr_dog_cnt || (wr_status && wr_data_i[StWarnBit]);
   assign ev_clr[StExpBit]  = wr_dog_cnt || (wr_status && wr_data_i[StExpBit]);

   for (genvar i = 0; i < NumFlags; i++) begin : g_flag
      wdt_flag u_flag (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .set_i  (ev_set[i]),
         .clr_i  (ev_clr[i]),
         .flag_o (ev_flag[i])
      );
   end

   assign wake_irq_o = ev_flag[StWakeBit];
   assign wake_req_o = ev_flag[StWakeBit];
   assign warn_irq_o = ev_flag[StWarnBit];
   assign warn_nmi_o = ev_flag[StWarnBit];
   assign rst_req_o  = ev_flag[StExpBit];

   // Read mux
   always_comb begin
      rd_data_o = '0;
      case (reg_addr_e'(rd_addr_i))
         RegWakeCfg: begin
            rd_data_o[WakeEnBit]         = wake_en_q;
            rd_data_o[PrescMsb:PrescLsb] = presc_q;
         end
         RegWakeCnt: rd_data_o = wake_cnt;
         RegWakeThr: rd_data_o = wake_thr_q;
         RegDogCfg: begin
            rd_data_o[DogEnBit]   = dog_en_q;
            rd_data_o[DogLockBit] = lock_q;
         end
         RegDogCnt:  rd_data_o = dog_cnt;
         RegWarnThr: rd_data_o = warn_thr_q;
         RegExpThr:  rd_data_o = exp_thr_q;
         RegStatus:  rd_data_o[NumFlags-1:0] = ev_flag;
         default: ;
      endcase
   end

   // R9
   lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q |=> lock_q);

   // R9
   locked_cfg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q |=> $stable(dog_en_q) && $stable(warn_thr_q) && $stable(exp_thr_q));

   // R8
   kick_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_dog_cnt |=> !warn_irq_o && !rst_req_o);

endmodule

// File: tb/tb_wdt_wake_top.sv
module tb_wdt_wake_top;

   localparam int unsigned CW = 32;
   localparam logic [3:0] A_WCFG = 4'd0, A_WCNT = 4'd1, A_WTHR = 4'd2, A_DCFG = 4'd3,
                          A_DCNT = 4'd4, A_WARN = 4'd5, A_EXP  = 4'd6, A_STAT = 4'd7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [3:0]    rd_addr = '0;
   logic [CW-1:0] rd_data;
   logic          wake_irq, wake_req, warn_irq, warn_nmi, rst_req;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   wdt_wake_top dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .wr_en_i    (wr_en),
      .wr_addr_i  (wr_addr),
      .wr_data_i  (wr_data),
      .rd_addr_i  (rd_addr),
      .rd_data_o  (rd_data),
      .wake_irq_o (wake_irq),
      .wake_req_o (wake_req),
      .warn_irq_o (warn_irq),
      .warn_nmi_o (warn_nmi),
      .rst_req_o  (rst_req)
   );

   // {address, write data, expected readback}
   localparam logic [67:0] VEC [6] = '{
      {A_WTHR, 32'h1234_5678, 32'h1234_5678},
      {A_WARN, 32'h0000_0100, 32'h0000_0100},
      {A_EXP,  32'h0000_0200, 32'h0000_0200},
      {A_WCFG, 32'hFFFF_FFF0, 32'h0000_FFF0},
      {A_DCFG, 32'h0000_0000, 32'h0000_0000},
      {A_WCNT, 32'hABCD_0000, 32'hABCD_0000}
   };

   task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [CW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [CW-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] v, v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 outputs", {27'd0, wake_irq, wake_req, warn_irq, warn_nmi, rst_req}, '0);
      rd(A_WARN, v); chk("R1 warn thr", v, '1);
      rd(A_EXP, v);  chk("R1 expire thr", v, '1);
      rd(A_WTHR, v); chk("R1 wake thr", v, '1);
      rd(A_DCNT, v); chk("R1 dog count", v, '0);
      rd(A_WCFG, v); chk("R1 wake cfg", v, '0);

      // R2 register table
      for (int i = 0; i < 6; i++) begin
         wr(VEC[i][67:64], VEC[i][63:32]);
         rd(VEC[i][67:64], v);
         chk("R2 readback", v, VEC[i][31:0]);
      end

      // R3 / R4 wakeup with prescale 3, threshold 2
      wr(A_WCNT, 0);
      wr(A_WTHR, 2);
      wr(A_WCFG, (32'd3 << 4) | 32'd1);
      repeat (7) @(negedge clk);
      rd(A_WCNT, v); chk("R3 count after 7 clocks", v, 1);
      @(negedge clk);
      rd(A_WCNT, v); chk("R3 count after 8 clocks", v, 2);
      chk("R4 irq not yet", {31'd0, wake_irq}, 0);
      @(negedge clk);
      chk("R4 wake irq", {31'd0, wake_irq}, 1);
      chk("R4 wake req", {31'd0, wake_req}, 1);
      wr(A_WCFG, 0);
      wr(A_STAT, 1);
      chk("R4 status clear", {31'd0, wake_irq}, 0);

      // R5 / R6 / R7 watchdog
      wr(A_DCNT, 0);
      wr(A_WARN, 10);
      wr(A_EXP, 20);
      wr(A_DCFG, 1);
      repeat (10) @(negedge clk);
      rd(A_DCNT, v); chk("R5 count per clock", v, 10);
      chk("R6 warn not yet", {31'd0, warn_irq}, 0);
      @(negedge clk);
      chk("R6 warn irq", {31'd0, warn_irq}, 1);
      chk("R6 warn nmi", {31'd0, warn_nmi}, 1);
      repeat (9) @(negedge clk);
      chk("R7 reset req not yet", {31'd0, rst_req}, 0);
      @(negedge clk);
      chk("R7 reset req", {31'd0, rst_req}, 1);

      // R8 keep-alive
      wr(A_DCNT, 0);
      chk("R8 warn cleared", {31'd0, warn_irq}, 0);
      chk("R8 reset req cleared", {31'd0, rst_req}, 0);
      rd(A_DCNT, v); chk("R8 count loaded", v, 0);

      // R11 clear wins, then re-assert
      repeat (11) @(negedge clk);
      chk("R11 warn back", {31'd0, warn_irq}, 1);
      wr(A_STAT, 2);
      chk("R11 clear wins", {31'd0, warn_irq}, 0);
      @(negedge clk);
      chk("R11 re-assert", {31'd0, warn_irq}, 1);

      // R5 hold while disabled
      wr(A_DCFG, 0);
      rd(A_DCNT, v);
      repeat (5) @(negedge clk);
      rd(A_DCNT, v2);
      chk("R5 hold when disabled", v2, v);

      // R9 lock
      wr(A_DCFG, 2);
      wr(A_DCFG, 1);
      rd(A_DCFG, v); chk("R9 enable write ignored", v, 2);
      wr(A_WARN, 5);
      rd(A_WARN, v); chk("R9 threshold write ignored", v, 10);
      wr(A_DCNT, 0);
      repeat (5) @(negedge clk);
      rd(A_DCNT, v); chk("R9 count write allowed, still stopped", v, 0);
      chk("R9 warn low", {31'd0, warn_irq}, 0);

      // R10 saturation
      wr(A_WCNT, 32'hFFFF_FFFE);
      wr(A_WCFG, 1);
      repeat (4) @(negedge clk);
      rd(A_WCNT, v); chk("R10 saturate", v, 32'hFFFF_FFFF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule